// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a 14-bit virtual address onto a 16-bit physical address through a table of four segments. The two most significant address bits pick a segment; the remaining twelve bits are an offset into it. Every segment has its own base, its own bound and its own read, write and execute permission bits. A translation request carries an access type: load, store or instruction fetch. One cycle later the block returns either the translated address or a fault code.

Privileged code loads the segment table through a separate write port, for example when the running process changes. Table writes and translation requests are sampled on the same clock edge. A request therefore always sees the table as it stood before any write in that same cycle.

Top module: `seg_xlat`

## Requirements
- R1: After reset, rsp_valid is 0 and rsp_fault and rsp_paddr are 0. All segment entries are cleared to base 0, bound 0 and no permissions, so any request then gets fault code 01.
- R2: rsp_valid is high in exactly the cycle after a cycle in which req_valid is high, and low otherwise. While rsp_valid is low, rsp_fault and rsp_paddr are 0.
- R3: req_vaddr[13:12] selects the segment and req_vaddr[11:0] is the offset. A successful translation returns base + offset on rsp_paddr with rsp_fault = 00.
- R4: An offset greater than or equal to the segment's 13-bit bound gives fault 01. A bound of 4096 admits every offset.
- R5: If base + offset does not fit in 16 bits, the result is fault 01.
- R6: The permission field is bit 0 read, bit 1 write, bit 2 execute. The access type is encoded 00 load, 01 store and 10 fetch, and needs R, W or X respectively. A missing permission gives fault 10. Access type 11 always gives fault 10.
- R7: When a request breaks both the bound (or overflow) rule and the permission rule, the fault is 01.
- R8: rsp_fault never takes the value 11. Whenever it is nonzero, rsp_paddr is 0.
- R9: A table write is applied only when tbl_wr_priv is high. A write with tbl_wr_priv low leaves the table unchanged.
- R10: A table write in the same cycle as a request does not affect that request. It affects only later requests.
- R11: Writing one segment entry leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request qualifier |
| req_vaddr | input | 14 | Virtual address: segment select in 13:12, offset in 11:0 |
| req_kind | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| tbl_wr_en | input | 1 | Segment table write strobe |
| tbl_wr_priv | input | 1 | Privilege qualifier for the table write |
| tbl_wr_idx | input | 2 | Segment entry to write |
| tbl_wr_base | input | 16 | New base address |
| tbl_wr_bound | input | 13 | New bound, 0 to 4096 |
| tbl_wr_perm | input | 3 | New permissions: bit 0 R, bit 1 W, bit 2 X |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 bound or overflow, 10 permission |

## Verification
Requests go to all four segments, with offsets just inside the bound, exactly on it, and at the 4096 limit. These separate a correct greater-or-equal bound compare from an off-by-one compare, and a correct segment select from a wrong one. Each access type is tried on segments that grant and that withhold the matching permission, and then on a segment that breaks both rules at once. Together these show which permission bit is decoded and which fault wins. Base values near the top of the address space show whether the overflow check works. Table writes made without privilege, made together with a request, and aimed at a neighbouring entry show whether a write is ignored, whether it lands on the right cycle, and whether it hits only the intended entry.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int VA_W  = 14;
    localparam int SEL_W = 2;
    localparam int OFF_W = VA_W - SEL_W;
    localparam int NSEG  = 1 << SEL_W;
    localparam int PA_W  = 16;
    localparam int BND_W = OFF_W + 1;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_BOUND = 2'b01,
        FLT_PERM  = 2'b10
    } fault_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [BND_W-1:0] bound;
        perm_t            perm;
    } seg_ent_t;

    function automatic logic perm_allows(perm_t p, acc_kind_e k);
        logic ok;
        case (k)
            ACC_LOAD:  ok = p.r;
            ACC_STORE: ok = p.w;
            ACC_FETCH: ok = p.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  seg_ent_t         wr_ent,
    input  logic [SEL_W-1:0] rd_idx,
    output seg_ent_t         rd_ent
);

    seg_ent_t ents [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (wr_en && (wr_idx == SEL_W'(g))) begin
                ents[g] <= wr_ent;
            end
        end
    end

    always_comb begin
        rd_ent = ents[rd_idx];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  seg_ent_t         ent,
    input  logic [OFF_W-1:0] off,
    input  acc_kind_e        kind,
    output logic [PA_W-1:0]  paddr,
    output fault_e           fault
);

    logic [PA_W:0] sum;
    logic          out_of_bound;
    logic          overflow;
    logic          perm_ok;

    always_comb begin
        sum          = {1'b0, ent.base} + {{(PA_W + 1 - OFF_W){1'b0}}, off};
        out_of_bound = {1'b0, off} >= ent.bound;
        overflow     = sum[PA_W];
        perm_ok      = perm_allows(ent.perm, kind);

        if (out_of_bound || overflow) begin
            fault = FLT_BOUND;
        end else if (!perm_ok) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end

        paddr = (fault == FLT_NONE) ? sum[PA_W-1:0] : '0;
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [13:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        tbl_wr_en,
    input  logic        tbl_wr_priv,
    input  logic [1:0]  tbl_wr_idx,
    input  logic [15:0] tbl_wr_base,
    input  logic [12:0] tbl_wr_bound,
    input  logic [2:0]  tbl_wr_perm,
    output logic        rsp_valid,
    output logic [15:0] rsp_paddr,
    output logic [1:0]  rsp_fault
);

    seg_ent_t        wr_ent;
    seg_ent_t        sel_ent;
    logic [PA_W-1:0] nxt_paddr;
    fault_e          nxt_fault;

    always_comb begin
        wr_ent.base  = tbl_wr_base;
        wr_ent.bound = tbl_wr_bound;
        wr_ent.perm  = perm_t'(tbl_wr_perm);
    end

    seg_table u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_wr_en && tbl_wr_priv),
        .wr_idx (tbl_wr_idx),
        .wr_ent (wr_ent),
        .rd_idx (req_vaddr[VA_W-1:OFF_W]),
        .rd_ent (sel_ent)
    );

    seg_check u_check (
        .ent   (sel_ent),
        .off   (req_vaddr[OFF_W-1:0]),
        .kind  (acc_kind_e'(req_kind)),
        .paddr (nxt_paddr),
        .fault (nxt_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_paddr <= req_valid ? nxt_paddr : '0;
            rsp_fault <= req_valid ? nxt_fault : FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        rsp_valid,
    input logic [15:0] rsp_paddr,
    input logic [1:0]  rsp_fault
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_fault == 2'b00 && rsp_paddr == 16'h0));

    // R8
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault != 2'b11);

    // R8
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'b00) |-> (rsp_paddr == 16'h0));

    // R6
    rsvd_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b11) |=> (rsp_fault != 2'b00));

endmodule

bind seg_xlat seg_xlat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/seg_xlat_tb.sv
`timescale 1ns/1ps
module seg_xlat_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [13:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        tbl_wr_en;
    logic        tbl_wr_priv;
    logic [1:0]  tbl_wr_idx;
    logic [15:0] tbl_wr_base;
    logic [12:0] tbl_wr_bound;
    logic [2:0]  tbl_wr_perm;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_base  [4];
    logic [12:0] m_bound [4];
    logic [2:0]  m_perm  [4];

    always #10 clk = ~clk;

    seg_xlat u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_priv(tbl_wr_priv), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_base(tbl_wr_base), .tbl_wr_bound(tbl_wr_bound), .tbl_wr_perm(tbl_wr_perm),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model built from the requirements: returns {fault, paddr}
    function automatic logic [17:0] model(logic [13:0] va, logic [1:0] kind);
        logic [1:0]  s    = va[13:12];
        logic [16:0] sum  = {1'b0, m_base[s]} + {5'b0, va[11:0]};
        logic        pok;
        case (kind)
            2'b00:   pok = m_perm[s][0];
            2'b01:   pok = m_perm[s][1];
            2'b10:   pok = m_perm[s][2];
            default: pok = 1'b0;
        endcase
        if ({1'b0, va[11:0]} >= m_bound[s] || sum[16]) return {2'b01, 16'h0};
        if (!pok) return {2'b10, 16'h0};
        return {2'b00, sum[15:0]};
    endfunction

    task automatic drive_wr(logic [1:0] idx, logic [15:0] b, logic [12:0] bd,
                            logic [2:0] p, logic priv);
        tbl_wr_en = 1'b1; tbl_wr_priv = priv; tbl_wr_idx = idx;
        tbl_wr_base = b; tbl_wr_bound = bd; tbl_wr_perm = p;
    endtask

    task automatic commit_wr(logic [1:0] idx, logic [15:0] b, logic [12:0] bd,
                             logic [2:0] p, logic priv);
        if (priv) begin
            m_base[idx] = b; m_bound[idx] = bd; m_perm[idx] = p;
        end
        tbl_wr_en = 1'b0; tbl_wr_priv = 1'b0;
    endtask

    task automatic wr_seg(logic [1:0] idx, logic [15:0] b, logic [12:0] bd,
                          logic [2:0] p, logic priv);
        @(negedge clk);
        drive_wr(idx, b, bd, p, priv);
        @(negedge clk);
        commit_wr(idx, b, bd, p, priv);
    endtask

    task automatic xlat(string tag, logic [13:0] va, logic [1:0] kind,
                        logic [1:0] exp_f, logic [15:0] exp_pa);
        logic [17:0] m;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        m = model(va, kind);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, exp_f});
        chk({tag, " paddr"}, {16'b0, rsp_paddr}, {16'b0, exp_pa});
        chk({tag, " model"}, {14'b0, rsp_fault, rsp_paddr}, {14'b0, m});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rst valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 rst fault", {30'b0, rsp_fault}, 32'd0);
        chk("R1 rst paddr", {16'b0, rsp_paddr}, 32'd0);
        xlat("R1 cleared seg2", 14'h2000, 2'b00, 2'b01, 16'h0);
        xlat("R1 cleared seg0", 14'h0000, 2'b10, 2'b01, 16'h0);
    endtask

    task automatic t_program();
        wr_seg(2'd0, 16'h0020, 13'h0100, 3'b101, 1'b1);
        wr_seg(2'd1, 16'hB000, 13'h1000, 3'b011, 1'b1);
        wr_seg(2'd2, 16'h0400, 13'h1000, 3'b011, 1'b1);
        wr_seg(2'd3, 16'hE500, 13'h0100, 3'b001, 1'b1);
    endtask

    task automatic t_basic();
        xlat("R3 load seg0", 14'h0023, 2'b00, 2'b00, 16'h0043);
        xlat("R3 fetch seg0", 14'h0010, 2'b10, 2'b00, 16'h0030);
        xlat("R3 store seg1", 14'h1015, 2'b01, 2'b00, 16'hB015);
        xlat("R3 load seg2", 14'h2015, 2'b00, 2'b00, 16'h0415);
        xlat("R3 load seg3", 14'h30FF, 2'b00, 2'b00, 16'hE5FF);
    endtask

    task automatic t_bound();
        xlat("R4 below bound", 14'h00FF, 2'b00, 2'b00, 16'h011F);
        xlat("R4 at bound", 14'h0100, 2'b00, 2'b01, 16'h0);
        xlat("R4 full 4K", 14'h1FFF, 2'b00, 2'b00, 16'hBFFF);
        xlat("R4 seg3 at bound", 14'h3100, 2'b00, 2'b01, 16'h0);
    endtask

    task automatic t_overflow();
        wr_seg(2'd3, 16'hF800, 13'h1000, 3'b001, 1'b1);
        xlat("R5 top fits", 14'h37FF, 2'b00, 2'b00, 16'hFFFF);
        xlat("R5 overflow", 14'h3800, 2'b00, 2'b01, 16'h0);
    endtask

    task automatic t_perm();
        xlat("R6 store no W", 14'h0010, 2'b01, 2'b10, 16'h0);
        xlat("R6 fetch no X", 14'h1010, 2'b10, 2'b10, 16'h0);
        xlat("R6 store seg3 R only", 14'h3010, 2'b01, 2'b10, 16'h0);
        xlat("R6 kind 11", 14'h1010, 2'b11, 2'b10, 16'h0);
        wr_seg(2'd2, 16'h0400, 13'h1000, 3'b110, 1'b1);
        xlat("R6 load no R", 14'h2010, 2'b00, 2'b10, 16'h0);
        xlat("R6 fetch X only", 14'h2010, 2'b10, 2'b00, 16'h0410);
    endtask

    task automatic t_priority();
        xlat("R7 bound over perm", 14'h0200, 2'b01, 2'b01, 16'h0);
        xlat("R7 overflow over perm", 14'h3900, 2'b10, 2'b01, 16'h0);
    endtask

    task automatic t_priv();
        wr_seg(2'd1, 16'h1234, 13'h0010, 3'b000, 1'b0);
        xlat("R9 unpriv ignored", 14'h1015, 2'b01, 2'b00, 16'hB015);
    endtask

    task automatic t_same_cycle();
        logic [17:0] m;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 14'h2020; req_kind = 2'b10;
        m = model(14'h2020, 2'b10);
        drive_wr(2'd2, 16'h3000, 13'h1000, 3'b100, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        commit_wr(2'd2, 16'h3000, 13'h1000, 3'b100, 1'b1);
        chk("R10 old table used", {14'b0, rsp_fault, rsp_paddr}, {14'b0, m});
        chk("R10 old paddr", {16'b0, rsp_paddr}, 32'h0420);
        xlat("R10 new table later", 14'h2020, 2'b10, 2'b00, 16'h3020);
    endtask

    task automatic t_isolation();
        xlat("R11 seg1 intact", 14'h1015, 2'b01, 2'b00, 16'hB015);
        xlat("R11 seg0 intact", 14'h0023, 2'b00, 2'b00, 16'h0043);
        xlat("R11 seg3 intact", 14'h3001, 2'b00, 2'b00, 16'hF801);
    endtask

    task automatic t_latency();
        @(negedge clk);
        chk("R2 idle valid", {31'b0, rsp_valid}, 32'd0);
        chk("R2 idle fault", {30'b0, rsp_fault}, 32'd0);
        chk("R2 idle paddr", {16'b0, rsp_paddr}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_bound[i] = '0; m_perm[i] = '0;
        end
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        tbl_wr_en = 1'b0; tbl_wr_priv = 1'b0; tbl_wr_idx = '0;
        tbl_wr_base = '0; tbl_wr_bound = '0; tbl_wr_perm = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_basic();
        t_latency();
        t_bound();
        t_overflow();
        t_perm();
        t_priority();
        t_priv();
        t_same_cycle();
        t_isolation();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule